// File: doc/BRIEF.md
# Reset Cause Register

This block is a 32-bit control and status register that tells software why the system last came out of reset, and lets software ask for a new reset. Five bits at the top of the word have meaning. Bit 31 marks a power-on reset. Bit 30 marks a soft power-on request and bit 29 a soft externally initiated reset request. Bits 28 and 27 mark power-on and externally initiated resets caused by buttons. Bits 26 to 0 always read as zero. The status bits (31, 28, 27) are cleared by writing one to them. The request bits (30, 29) are set by writing one to them, and a write of zero leaves them as they are.

An internal counter tracks how many system resets the block has seen. When a system reset arrives while the counter is zero, it is treated as a true power-on: the register is loaded with bit 31 alone. Later resets leave the register unchanged, so the recorded cause stays readable. The counter stops at its maximum value instead of wrapping back to zero. A soft power-on request clears the counter, so the reset that follows is seen as a power-on again. Each accepted write that carries a request raises a reset request pulse on the output, one cycle long.

The register sits in the upper word of an 8-byte slot. An access qualified as lower word returns zero on a read and has no effect on a write. Buttons are debounced outside this block, and the reset request is distributed outside it too.

Top module: `rst_cause_reg`

## Requirements
- R1: After the synchronous `rst`, an upper-word read returns 0x00000000 and `rst_req_o` stays low.
- R2: A cycle with `sys_rst_i` high while the reset count is zero loads the register with exactly 0x80000000 (only bit 31).
- R3: A cycle with `sys_rst_i` high while the reset count is nonzero leaves the register unchanged.
- R4: Write data is masked with 0xF8000000, so writes to bits 26:0 have no effect and those bits always read as zero.
- R5: Writing one to bit 31, 28 or 27 clears that bit. Writing zero to it leaves it unchanged.
- R6: Writing one to bit 30 or 29 sets that bit. Writing zero to it leaves it unchanged.
- R7: An accepted write with bit 30 set makes `rst_req_o` high for exactly the next cycle. It also clears the reset count, so the next system reset loads 0x80000000 again.
- R8: An accepted write with bit 29 set and bit 30 clear makes `rst_req_o` high for exactly the next cycle and does not clear the reset count.
- R9: A lower-word access (`acc_hi_i` = 0) reads back 0 and, when it is a write, changes nothing.
- R10: A pulse on `btn_por_i` sets bit 28 and a pulse on `btn_xir_i` sets bit 27.
- R11: The reset count saturates at 2^CNT_W-1. Any number of further system resets never makes it look like a power-on.
- R12: A write in the same cycle as `sys_rst_i` is ignored and raises no request.
- R13: Read data appears on `rdata_o` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears register and count |
| sys_rst_i | input | 1 | System reset event, one event per cycle high |
| btn_por_i | input | 1 | Debounced power-on button pulse |
| btn_xir_i | input | 1 | Debounced external-reset button pulse |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_hi_i | input | 1 | 1 = upper word of the slot, 0 = lower word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The hardest state to reach is the saturated reset count. The count is never visible at the ports. It shows only as the absence of a power-on reload after a later system reset. The stimulus first drives more system resets than the count can hold. It then writes a soft external request, which does not clear the count, and applies one more reset; the register must keep its value. The soft power-on path is checked the other way round: after a bit-30 write, the very next system reset must reload 0x80000000.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int WORD_W   = 32;
  localparam int BIT_POR  = 31;
  localparam int BIT_SPOR = 30;
  localparam int BIT_SXIR = 29;
  localparam int BIT_BPOR = 28;
  localparam int BIT_BXIR = 27;
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hF800_0000;
  localparam logic [WORD_W-1:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [WORD_W-1:0] W1S_MASK  = 32'h6000_0000;
  localparam logic [WORD_W-1:0] POR_VALUE = 32'h8000_0000;
endpackage

// File: rtl/rst_cause_count.sv
module rst_cause_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (clr_i)
      cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rst_cause_bits.sv
module rst_cause_bits
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_evt_i,
  input  logic              first_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wval_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic [WORD_W-1:0] stat_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (W1C_MASK[i] || W1S_MASK[i]) begin : g_live
      localparam logic LOAD_VAL = (i == BIT_POR);
      logic bit_q;
      logic btn_set;
      if (i == BIT_BPOR) begin : g_bp
        assign btn_set = btn_por_i;
      end else if (i == BIT_BXIR) begin : g_bx
        assign btn_set = btn_xir_i;
      end else begin : g_nb
        assign btn_set = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          bit_q <= 1'b0;
        end else if (sys_evt_i && first_i) begin
          bit_q <= LOAD_VAL;
        end else begin
          if (!sys_evt_i && wr_i && wval_i[i])
            bit_q <= W1S_MASK[i];
          if (btn_set)
            bit_q <= 1'b1;
        end
      end
      assign stat_o[i] = bit_q;
    end else begin : g_zero
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rst_cause_req.sv
module rst_cause_req (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst)
      pulse_q <= 1'b0;
    else
      pulse_q <= fire_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sys_rst_i,
  input  logic        btn_por_i,
  input  logic        btn_xir_i,
  input  logic        acc_en_i,
  input  logic        acc_we_i,
  input  logic        acc_hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rst_req_o
);
  logic [WORD_W-1:0] wval;
  logic              wr_ok;
  logic              rd_ok;
  logic              first;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] rdata_q;

  assign wval  = wdata_i & KEEP_MASK;
  assign wr_ok = acc_en_i && acc_we_i && acc_hi_i && !sys_rst_i;
  assign rd_ok = acc_en_i && !acc_we_i;

  rst_cause_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (sys_rst_i),
    .clr_i  (wr_ok && wval[BIT_SPOR]),
    .cnt_o  (cnt_q),
    .zero_o (first)
  );

  rst_cause_bits u_bits (
    .clk       (clk),
    .rst       (rst),
    .sys_evt_i (sys_rst_i),
    .first_i   (first),
    .wr_i      (wr_ok),
    .wval_i    (wval),
    .btn_por_i (btn_por_i),
    .btn_xir_i (btn_xir_i),
    .stat_o    (stat_q)
  );

  rst_cause_req u_req (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (wr_ok && (wval[BIT_SPOR] || wval[BIT_SXIR])),
    .pulse_o (rst_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_ok)
      rdata_q <= acc_hi_i ? stat_q : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rst_cause_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_rst_i,
  input logic             btn_por_i,
  input logic             btn_xir_i,
  input logic             acc_en_i,
  input logic             acc_we_i,
  input logic             acc_hi_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      stat
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  // R4
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata_o & ~KEEP_MASK) == '0);

  // R2
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i && cnt == '0) |=> stat == POR_VALUE);

  // R3
  later_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i && cnt != '0 && !btn_por_i && !btn_xir_i) |=> $stable(stat));

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(acc_en_i && acc_we_i && acc_hi_i && !sys_rst_i &&
                        (wdata_i[BIT_SPOR] || wdata_i[BIT_SXIR])));

  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_TOP && sys_rst_i) |=> cnt == CNT_TOP);

  // R9
  lo_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en_i && acc_we_i && !acc_hi_i && !sys_rst_i && !btn_por_i && !btn_xir_i)
      |=> $stable(stat));
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_rst_i (sys_rst_i),
  .btn_por_i (btn_por_i),
  .btn_xir_i (btn_xir_i),
  .acc_en_i  (acc_en_i),
  .acc_we_i  (acc_we_i),
  .acc_hi_i  (acc_hi_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rst_req_o (rst_req_o),
  .cnt       (cnt_q),
  .stat      (stat_q)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sys_rst_i = 1'b0, btn_por_i = 1'b0, btn_xir_i = 1'b0;
  logic        acc_en_i = 1'b0, acc_we_i = 1'b0, acc_hi_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_reg = '0;
  int          m_cnt = 0;
  logic        exp_req_now = 1'b0;
  logic        exp_req_d = 1'b0;
  logic        rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rst_cause_reg #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .sys_rst_i(sys_rst_i), .btn_por_i(btn_por_i),
    .btn_xir_i(btn_xir_i), .acc_en_i(acc_en_i), .acc_we_i(acc_we_i),
    .acc_hi_i(acc_hi_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rst_req_o(rst_req_o)
  );

  always @(posedge clk) begin
    rd_d      <= acc_en_i && !acc_we_i;
    exp_req_d <= exp_req_now;
  end

  // monitor: compares read data and request pulses against expectations
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_d) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata_o !== e) begin
          errors++;
          $display("FAIL %s: rdata got %h expected %h", t, rdata_o, e);
        end
      end
      if (rst_req_o || exp_req_d) begin
        checks++;
        if (rst_req_o !== exp_req_d) begin
          errors++;
          $display("FAIL R7/R8/R12: rst_req_o got %b expected %b", rst_req_o, exp_req_d);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    {sys_rst_i, btn_por_i, btn_xir_i, acc_en_i, acc_we_i, acc_hi_i} = '0;
    wdata_i = '0;
    exp_req_now = 1'b0;
  endtask

  task automatic model_sys();
    if (m_cnt == 0) m_reg = 32'h8000_0000;
    if (m_cnt < CNT_MAX) m_cnt++;
  endtask

  task automatic do_sys();
    idle();
    sys_rst_i = 1'b1;
    model_sys();
  endtask

  task automatic do_write(input logic hi, input logic [31:0] d, input logic with_sys);
    logic [31:0] v;
    idle();
    acc_en_i = 1'b1; acc_we_i = 1'b1; acc_hi_i = hi; wdata_i = d;
    sys_rst_i = with_sys;
    if (with_sys) begin
      model_sys();
    end else if (hi) begin
      v = d & 32'hF800_0000;
      m_reg = (m_reg & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
      if (v[30]) m_cnt = 0;
      exp_req_now = v[30] | v[29];
    end
  endtask

  task automatic do_btn(input logic p, input logic x);
    idle();
    btn_por_i = p; btn_xir_i = x;
    if (p) m_reg[28] = 1'b1;
    if (x) m_reg[27] = 1'b1;
  endtask

  task automatic do_read(input logic hi, input string tag);
    idle();
    acc_en_i = 1'b1; acc_we_i = 1'b0; acc_hi_i = hi;
    exp_q.push_back(hi ? m_reg : 32'h0);
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    do_read(1'b1, "R1 reset state");
    do_sys();
    do_read(1'b1, "R2 first reset loads power-on");
    do_write(1'b1, 32'h07FF_FFFF, 1'b0);
    do_read(1'b1, "R4 low bits masked");
    do_write(1'b0, 32'hFFFF_FFFF, 1'b0);
    do_read(1'b0, "R9 lower word reads zero");
    do_read(1'b1, "R9 lower write ignored");
    do_write(1'b1, 32'h2000_0000, 1'b0);
    do_read(1'b1, "R6 R8 soft external set R13");
    do_write(1'b1, 32'h0000_0000, 1'b0);
    do_read(1'b1, "R5 R6 zero write keeps");
    do_sys();
    do_read(1'b1, "R3 R8 later reset keeps");
    do_btn(1'b1, 1'b1);
    do_read(1'b1, "R10 buttons set");
    do_write(1'b1, 32'h1000_0000, 1'b0);
    do_read(1'b1, "R5 clear bit 28");
    do_write(1'b1, 32'h8800_0000, 1'b0);
    do_read(1'b1, "R5 clear bits 31 27");
    do_write(1'b1, 32'h4000_0000, 1'b0);
    do_read(1'b1, "R6 soft power-on set");
    do_sys();
    do_read(1'b1, "R7 count cleared reload");
    do_write(1'b1, 32'h4000_0000, 1'b1);
    do_read(1'b1, "R12 write during reset ignored");
    for (int k = 0; k < CNT_MAX + 5; k++) do_sys();
    do_write(1'b1, 32'h2000_0000, 1'b0);
    do_sys();
    do_read(1'b1, "R11 saturated count no reload");
    repeat (4) idle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13: pending reads got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule